// File: doc/BRIEF.md
# Cascaded Prescaled Coarse Delay Timer

This block is a triggered coarse delay timer. It runs on a single 80 MHz reference clock. All of its stages are clock enables on that clock. Once a trigger is accepted, the reference feeds a two-stage prescaler: a /4 stage, then a /16 stage, giving one tick every 64 reference cycles. Those ticks drive a cascade of programmable down-counters. The mode input selects how much of the cascade is used:

- **Short mode** uses none of it.
- **Medium mode** uses a single final counter.
- **Long mode** uses a fixed divider, an intermediate counter and the final counter.

Completion from the counters is sampled on the /64 tick. It is then retimed onto the /4 tick. The retimed edge ends the count and produces a one-cycle done pulse.

After each delay, a fixed reload phase of 66 reference cycles keeps the block busy before a new trigger can start a run. While the block is not counting, every programmable counter is held at its preset. The presets and the mode in effect at the acceptance edge govern the whole run.

Timing convention: the acceptance edge is the rising clock edge at which `trig_i` is seen high while idle. That edge is edge 0, and later edges are counted from it.

Top module: `dly_coarse_timer`

## Requirements
- R1: After reset `busy_o` and `done_o` are low.
- R2: A trigger seen while idle is accepted: `busy_o` is high from edge 0 on. Changes to `mode_i`, `cnt_lo_i` or `cnt_hi_i` after edge 0 have no effect on that run.
- R3: Short mode (`mode_i` = 0) bypasses the counters, and code 3 behaves the same. `done_o` is high in the cycle after edge 68.
- R4: Medium mode (`mode_i` = 1) uses N = `cnt_lo_i[14:0]`, so bit 15 is ignored. `done_o` is high after edge 64·(N+1)+4.
- R5: Long mode (`mode_i` = 2) uses M = `cnt_hi_i` and N = `cnt_lo_i`. With D being the fixed divider parameter `LONG_DIV` (default 32768), `done_o` is high after edge 64·(D·M+N+1)+4.
- R6: A programmed count of zero is treated as one, in both medium and long modes.
- R7: `done_o` is a single-cycle pulse.
- R8: With the done pulse after edge T, `busy_o` stays high through edge T+65 and is low after edge T+66.
- R9: Triggers while busy are ignored. This includes the edge following the done pulse and the last edge of the reload phase: they neither restart the run nor start a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 80 MHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Start request, sampled each edge |
| mode_i | input | 2 | 0 short, 1 medium, 2 long, 3 short |
| cnt_lo_i | input | 16 | Final counter preset |
| cnt_hi_i | input | 16 | Intermediate counter preset (long mode) |
| done_o | output | 1 | One-cycle end-of-delay pulse |
| busy_o | output | 1 | High from acceptance to end of reload |

## Verification
Two events can coincide in one cycle: the done pulse or the reload exit, and a fresh trigger. The bench raises `trig_i` for the edge right after the done pulse and again for the final reload edge, which is the edge where the block returns to idle. It then checks that `busy_o` is low one and two edges later, so neither trigger was taken. Some runs also pulse the trigger and scramble the mode and presets mid-count. These runs are judged by the done edge landing exactly where the sampled settings predict.

// File: rtl/dly_pkg.sv
package dly_pkg;
  typedef enum logic [1:0] {
    MODE_SHORT = 2'd0,
    MODE_MED   = 2'd1,
    MODE_LONG  = 2'd2,
    MODE_ALT   = 2'd3
  } dly_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_RLD  = 2'd2
  } dly_state_e;
endpackage

// File: rtl/dly_prescaler.sv
module dly_prescaler #(
  parameter int P1_W = 2,
  parameter int P2_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_mid_o,
  output logic tick_out_o
);
  logic [P1_W-1:0] p1_q;
  logic [P2_W-1:0] p2_q;

  assign tick_mid_o = en_i && (p1_q == '1);
  assign tick_out_o = tick_mid_o && (p2_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q <= '0;
      p2_q <= '0;
    end else if (clr_i) begin
      p1_q <= '0;
      p2_q <= '0;
    end else if (en_i) begin
      p1_q <= p1_q + 1'b1;
      if (tick_mid_o) p2_q <= p2_q + 1'b1;
    end
  end
endmodule

// File: rtl/dly_downcnt.sv
module dly_downcnt #(
  parameter int W    = 16,
  parameter bit WRAP = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] preset_i,
  input  logic         en_i,
  output logic         tc_o,
  output logic         done_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] preset_c;
  logic         done_q;

  // zero preset clamps to one
  assign preset_c = (preset_i == '0) ? ONE : preset_i;
  assign tc_o     = en_i && (cnt_q == ONE);
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= ONE;
      done_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= preset_c;
      done_q <= 1'b0;
    end else if (en_i) begin
      if (cnt_q == ONE) begin
        done_q <= 1'b1;
        if (WRAP) cnt_q <= preset_c;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R6
  cnt_never_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0);
endmodule

// File: rtl/dly_coarse_timer.sv
module dly_coarse_timer
  import dly_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int P1_W       = 2,
  parameter int P2_W       = 4,
  parameter int LONG_DIV   = 32768,
  parameter int RELOAD_CYC = 66
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] cnt_lo_i,
  input  logic [CNT_W-1:0] cnt_hi_i,
  output logic             done_o,
  output logic             busy_o
);
  localparam int DIV_W = $clog2(LONG_DIV + 1);
  localparam int RLD_W = $clog2(RELOAD_CYC);
  localparam logic [RLD_W-1:0] RLD_LAST = RLD_W'(RELOAD_CYC - 1);
  localparam logic [CNT_W-1:0] MED_MASK = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [DIV_W-1:0] DIV_PRE  = DIV_W'(LONG_DIV);

  dly_state_e       state_q;
  dly_mode_e        mode_q;
  logic [RLD_W-1:0] rld_q;
  logic             sync1_q, done_q;
  logic             run, load, accept, fire;
  logic             tick4, tick64;
  logic             div_en, div_tc, div_done;
  logic             mid_tc, mid_done;
  logic             fin_en, fin_tc, fin_done, cmp_done;
  logic [CNT_W-1:0] fin_pre;

  assign run    = (state_q == ST_RUN);
  assign load   = !run;
  assign accept = (state_q == ST_IDLE) && trig_i;
  assign fire   = run && tick4 && sync1_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  dly_prescaler #(.P1_W(P1_W), .P2_W(P2_W)) u_pre (
    .clk_i, .rst_ni, .clr_i(load), .en_i(run),
    .tick_mid_o(tick4), .tick_out_o(tick64)
  );

  // medium mode ignores the top preset bit
  assign fin_pre = (dly_mode_e'(mode_i) == MODE_MED) ? (cnt_lo_i & MED_MASK) : cnt_lo_i;
  assign div_en  = tick64 && (mode_q == MODE_LONG);
  assign fin_en  = tick64 && ((mode_q == MODE_MED) || ((mode_q == MODE_LONG) && mid_done));

  always_comb begin
    unique case (mode_q)
      MODE_MED, MODE_LONG: cmp_done = fin_done;
      default:             cmp_done = 1'b1;
    endcase
  end

  dly_downcnt #(.W(DIV_W), .WRAP(1'b1)) u_div (
    .clk_i, .rst_ni, .load_i(load), .preset_i(DIV_PRE), .en_i(div_en),
    .tc_o(div_tc), .done_o(div_done)
  );

  dly_downcnt #(.W(CNT_W), .WRAP(1'b0)) u_mid (
    .clk_i, .rst_ni, .load_i(load), .preset_i(cnt_hi_i), .en_i(div_tc),
    .tc_o(mid_tc), .done_o(mid_done)
  );

  dly_downcnt #(.W(CNT_W), .WRAP(1'b0)) u_fin (
    .clk_i, .rst_ni, .load_i(load), .preset_i(fin_pre), .en_i(fin_en),
    .tc_o(fin_tc), .done_o(fin_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_SHORT;
      rld_q   <= '0;
      sync1_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fire;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RUN;
          mode_q  <= dly_mode_e'(mode_i);
          sync1_q <= 1'b0;
        end
        ST_RUN: begin
          // first sync on /64 tick, second on /4 tick
          if (tick64) sync1_q <= cmp_done;
          if (fire) begin
            state_q <= ST_RLD;
            rld_q   <= '0;
          end
        end
        default: begin
          sync1_q <= 1'b0;
          if (rld_q == RLD_LAST) state_q <= ST_IDLE;
          else                   rld_q   <= rld_q + 1'b1;
        end
      endcase
    end
  end

  // R2
  trig_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && trig_i) |=> busy_o);
  // R3
  done_after_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(sync1_q));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  reload_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(rld_q) == RLD_LAST));
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !(state_q == ST_RLD && rld_q == RLD_LAST)) |=> busy_o);
endmodule

// File: tb/sim_dly_coarse_timer.sv
module sim_dly_coarse_timer;
  localparam int LDIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] lo = 16'd0, hi = 16'd0;
  logic        done, busy;
  int          n_chk = 0, n_fail = 0;
  int          cyc = 0;

  always #2.5 clk = ~clk;

  dly_coarse_timer #(.LONG_DIV(LDIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .mode_i(mode),
    .cnt_lo_i(lo), .cnt_hi_i(hi), .done_o(done), .busy_o(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_edge(input int md, input int l, input int h);
    int x, n, m;
    if (md == 1) begin
      n = l & 32'h7fff;
      x = (n == 0) ? 1 : n;
    end else if (md == 2) begin
      n = (l == 0) ? 1 : l;
      m = (h == 0) ? 1 : h;
      x = LDIV * m + n;
    end else x = 0;
    return 64 * (x + 1) + 4;
  endfunction

  function automatic string mreq(input int md);
    return (md == 1) ? "R4" : (md == 2) ? "R5" : "R3";
  endfunction

  task automatic run_case(input int md, input int l, input int h, input bit pert);
    int exp, k, dk;
    exp = exp_edge(md, l, h);
    @(negedge clk);
    mode = 2'(md); lo = 16'(l); hi = 16'(h); trig = 1'b1;
    @(posedge clk);
    @(negedge clk);
    trig = 1'b0;
    chk("R2 busy after accept", int'(busy), 1);
    k = 0; dk = -1;
    while (dk < 0 && k < exp + 10) begin
      @(posedge clk); @(negedge clk); k++;
      if (pert && k == 20) begin
        mode = 2'($urandom % 4); lo = 16'($urandom); hi = 16'($urandom); trig = 1'b1;
      end
      if (pert && k == 21) trig = 1'b0;
      if (done) dk = k;
    end
    chk({mreq(md), pert ? " R2 done edge after perturb" : " done edge"}, dk, exp);
    if (dk < 0) return;
    trig = 1'b1;  // R9: trigger in the edge after done
    @(posedge clk); @(negedge clk); k++;
    trig = 1'b0;
    chk("R7 done width", int'(done), 0);
    while (k < dk + 65) begin
      @(posedge clk); @(negedge clk); k++;
    end
    chk("R8 busy through reload", int'(busy), 1);
    trig = 1'b1;  // R9: trigger on final reload edge
    @(posedge clk); @(negedge clk);
    trig = 1'b0;
    chk("R8 busy low after reload", int'(busy), 0);
    @(posedge clk); @(negedge clk);
    chk("R9 trigger while busy ignored", int'(busy), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    #1;
    chk("R1 busy reset", int'(busy), 0);
    chk("R1 done reset", int'(done), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy idle", int'(busy), 0);
    run_case(0, 5, 5, 1'b0);        // R3
    run_case(3, 9, 9, 1'b0);        // R3 alternate code
    run_case(1, 1, 0, 1'b0);        // R4
    run_case(1, 0, 0, 1'b0);        // R6 medium zero
    run_case(1, 32'h8003, 0, 1'b0); // R4 bit 15 ignored
    run_case(2, 0, 0, 1'b0);        // R6 long zeros
    run_case(2, 5, 3, 1'b0);        // R5
    run_case(1, 7, 0, 1'b1);        // R2 perturbed
    run_case(2, 2, 2, 1'b1);        // R2 perturbed
    for (int i = 0; i < 16; i++) begin
      int md, l, h;
      md = int'($urandom % 4);
      l  = (md == 2) ? int'($urandom % 30) : int'($urandom % 50);
      h  = int'($urandom % 6);
      run_case(md, l, h, 1'($urandom % 2));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule